// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request port and an external 32K x 8 asynchronous static RAM. A client raises a one-cycle request carrying a read/write flag, a 15-bit word address and a byte of write data. The sequencer then drives the memory's active-low select, output-enable and write strobes, its address lines and the data bus, and finishes with a one-cycle done pulse. Read data is returned on a held output register.

The memory has no clock, so every timing limit is met by counting system clocks. Three compile-time parameters set the number of clocks in the read access window, in the write strobe window, and in the bus release gap after a read. Each count is the ceiling of the nanosecond limit divided by the clock period. A write that follows a read too closely waits out the rest of the release gap before it drives the bus. During a write the sequencer drops write enable one clock before it stops driving data. The data bus leaves the block as a split pad interface: output value, output enable and input value.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During reset and whenever idle, mem_cs_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, and busy and done are 0. An asynchronous reset in the middle of an operation returns these outputs to those values at once.
- R2: A read accepted on a clock edge holds mem_cs_n=0, mem_oe_n=0 and mem_we_n=1 for exactly ACC_CYC cycles, starting in the cycle after acceptance, with mem_addr equal to the request address.
- R3: For a read, done is high for a single cycle, ACC_CYC+1 cycles after the acceptance edge, and rsp_rdata then holds the byte present on mem_dq_in in the last cycle of the access window.
- R4: A write holds mem_cs_n=0, mem_we_n=0, mem_oe_n=1 and mem_dq_oe=1 for exactly WE_CYC cycles, with mem_addr and mem_dq_out equal to the request address and data.
- R5: After the write strobe window, mem_dq_oe stays 1 for exactly one more cycle with mem_we_n=1, and done follows in the next cycle.
- R6: Between a read's strobe release and the first cycle in which a write drives the bus, at least TURN_CYC cycles pass with mem_oe_n=1 and mem_dq_oe=0. A write accepted in the done cycle of a read therefore spends TURN_CYC-1 extra cycles before driving.
- R7: A write accepted when no read ended within the last TURN_CYC cycles drives the bus in the cycle after acceptance, and its done comes WE_CYC+2 cycles after the acceptance edge.
- R8: A request presented while busy is 1 is ignored: the address, strobes and memory contents are unaffected, and no extra done pulse appears.
- R9: busy is 1 from the cycle after a request is accepted up to the cycle before done. It is 0 in the done cycle, and a new request can be accepted in that cycle.
- R10: mem_oe_n=0 never coincides with mem_we_n=0 or with mem_dq_oe=1.
- R11: mem_addr is stable throughout every stretch in which mem_cs_n is 0, and mem_dq_out is stable throughout every stretch in which mem_we_n is 0.
- R12: rsp_rdata keeps the last read value through subsequent writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 selects write, 0 selects read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Byte to store on a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Byte captured by the most recent read |
| mem_addr | output | ADDR_W | Address lines to the memory |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DATA_W | Data bus value driven on writes |
| mem_dq_oe | output | 1 | Data bus pad drive enable |
| mem_dq_in | input | DATA_W | Data bus value seen from the memory |

## Verification
The bench builds the sequencer with ACC_CYC=3, WE_CYC=2 and TURN_CYC=3, so the access and strobe windows are short but longer than one cycle. The release gap is long enough that a write issued right after a read spends two visible cycles waiting before it drives. Its memory model returns a garbage byte until output enable has been low for ACC_CYC cycles, so a capture taken one cycle early shows up as wrong data. It also checks writes issued after an idle stretch, to see that they skip the gap.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_WR_GAP   = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_WR_HOLD  = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  function automatic strobe_t strobe_for(input seq_state_e st);
    strobe_t s;
    s = STROBE_IDLE;
    case (st)
      ST_RD_ACC: begin
        s.cs_n = 1'b0;
        s.oe_n = 1'b0;
      end
      ST_WR_PULSE: begin
        s.cs_n  = 1'b0;
        s.we_n  = 1'b0;
        s.dq_oe = 1'b1;
      end
      ST_WR_HOLD: begin
        s.dq_oe = 1'b1;
      end
      default: s = STROBE_IDLE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_turn_timer.sv
module sram_turn_timer #(
  parameter int unsigned TURN_CYC = 2,
  parameter int unsigned TW       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic drive_ok
);

  localparam logic [TW-1:0] TURN_LD = TW'(TURN_CYC);

  logic [TW-1:0] rem_q;
  logic [TW-1:0] rem_d;

  always_comb begin
    rem_d = rem_q;
    if (start) begin
      rem_d = TURN_LD;
    end else if (rem_q != '0) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else begin
      rem_q <= rem_d;
    end
  end

  // A transition taken on the coming edge sees the gap complete once one cycle is left.
  assign drive_ok = (rem_q <= TW'(1));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned ACC_CYC = 5,
  parameter int unsigned WE_CYC  = 5,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             phase_last,
  input  logic             turn_ok,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic             accept,
  output logic             phase_load,
  output logic [CNT_W-1:0] phase_val,
  output logic             rd_end,
  output logic             wr_end
);

  localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LD  = CNT_W'(WE_CYC - 1);

  always_comb begin
    state_d    = state_q;
    accept     = 1'b0;
    phase_load = 1'b0;
    phase_val  = '0;
    rd_end     = 1'b0;
    wr_end     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (!req_write) begin
            state_d    = ST_RD_ACC;
            phase_load = 1'b1;
            phase_val  = ACC_LD;
          end else if (turn_ok) begin
            state_d    = ST_WR_PULSE;
            phase_load = 1'b1;
            phase_val  = WE_LD;
          end else begin
            state_d = ST_WR_GAP;
          end
        end
      end
      ST_RD_ACC: begin
        if (phase_last) begin
          state_d = ST_IDLE;
          rd_end  = 1'b1;
        end
      end
      ST_WR_GAP: begin
        if (turn_ok) begin
          state_d    = ST_WR_PULSE;
          phase_load = 1'b1;
          phase_val  = WE_LD;
        end
      end
      ST_WR_PULSE: begin
        if (phase_last) begin
          state_d = ST_WR_HOLD;
        end
      end
      ST_WR_HOLD: begin
        state_d = ST_IDLE;
        wr_end  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ACC_CYC  = 5,
  parameter int unsigned WE_CYC   = 5,
  parameter int unsigned TURN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned PHASE_MAX = (ACC_CYC > WE_CYC) ? ACC_CYC : WE_CYC;
  localparam int unsigned CNT_W     = cnt_width(PHASE_MAX);
  localparam int unsigned TW        = cnt_width(TURN_CYC);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1_n;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_q_n  <= rst_s1_n;
    end
  end

  seq_state_e       state_q;
  seq_state_e       state_d;
  logic             accept;
  logic             phase_load;
  logic [CNT_W-1:0] phase_val;
  logic             phase_last;
  logic             turn_ok;
  logic             rd_end;
  logic             wr_end;

  sram_seq_fsm #(
    .ACC_CYC (ACC_CYC),
    .WE_CYC  (WE_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .phase_last (phase_last),
    .turn_ok    (turn_ok),
    .state_q    (state_q),
    .state_d    (state_d),
    .accept     (accept),
    .phase_load (phase_load),
    .phase_val  (phase_val),
    .rd_end     (rd_end),
    .wr_end     (wr_end)
  );

  sram_wait_cnt #(
    .CNT_W (CNT_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (phase_load),
    .load_val (phase_val),
    .last     (phase_last)
  );

  sram_turn_timer #(
    .TURN_CYC (TURN_CYC),
    .TW       (TW)
  ) u_turn (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .start    (rd_end),
    .drive_ok (turn_ok)
  );

  // Request capture, clock-enabled by acceptance.
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  strobe_t           strobe_q;
  strobe_t           strobe_d;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // Capture on the closing edge of the access window, strobes still low.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rdata_q <= '0;
    end else if (rd_end) begin
      rdata_q <= mem_dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= rd_end | wr_end;
    end
  end

  // Strobes come straight from flops fed by the next state.
  always_comb begin
    strobe_d = strobe_for(state_d);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      strobe_q <= STROBE_IDLE;
    end else begin
      strobe_q <= strobe_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_cs_n   = strobe_q.cs_n;
  assign mem_oe_n   = strobe_q.oe_n;
  assign mem_we_n   = strobe_q.we_n;
  assign mem_dq_oe  = strobe_q.dq_oe;

endmodule

// File: rtl/sram_seq_ctrl_sva.sv
module sram_seq_ctrl_sva #(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ACC_CYC  = 5,
  parameter int unsigned WE_CYC   = 5,
  parameter int unsigned TURN_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  logic [15:0] rd_lo;
  logic [15:0] wr_lo;
  logic [15:0] rel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_lo   <= '0;
      wr_lo   <= '0;
      rel_cnt <= 16'(TURN_CYC);
    end else begin
      rd_lo   <= !mem_oe_n ? ((rd_lo != '1) ? rd_lo + 16'd1 : rd_lo) : '0;
      wr_lo   <= !mem_we_n ? ((wr_lo != '1) ? wr_lo + 16'd1 : wr_lo) : '0;
      rel_cnt <= !mem_oe_n ? '0 : ((rel_cnt != '1) ? rel_cnt + 16'd1 : rel_cnt);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  p_rd_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (32'(rd_lo) >= ACC_CYC));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_we_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (32'(wr_lo) >= WE_CYC));

  p_we_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_cs_n));

  p_we_before_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> $past(mem_we_n));

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (32'(rel_cnt) >= TURN_CYC));

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_no_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_sva #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .ACC_CYC  (ACC_CYC),
  .WE_CYC   (WE_CYC),
  .TURN_CYC (TURN_CYC)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .req_valid  (req_valid),
  .busy       (busy),
  .done       (done),
  .mem_addr   (mem_addr),
  .mem_cs_n   (mem_cs_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_seq_ctrl_tb.sv
module sram_seq_ctrl_tb;

  localparam int TB_ACC  = 3;
  localparam int TB_WE   = 2;
  localparam int TB_TURN = 3;
  localparam int AW      = 15;
  localparam int DW      = 8;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 15'h0000, 8'h11},
    '{1'b0, 15'h0000, 8'h00},
    '{1'b1, 15'h7FFF, 8'hEE},
    '{1'b1, 15'h1234, 8'h5A},
    '{1'b0, 15'h7FFF, 8'h00},
    '{1'b0, 15'h1234, 8'h00},
    '{1'b1, 15'h0015, 8'hFF},
    '{1'b0, 15'h0015, 8'h00},
    '{1'b0, 15'h2A0A, 8'h00},
    '{1'b1, 15'h0A01, 8'h96},
    '{1'b0, 15'h0A01, 8'h00}
  };

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          busy;
  logic          done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n;
  logic          mem_oe_n;
  logic          mem_we_n;
  logic [DW-1:0] mem_dq_out;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_in;

  int n_tests = 0;
  int n_fail  = 0;

  sram_seq_ctrl #(
    .ADDR_W   (AW),
    .DATA_W   (DW),
    .ACC_CYC  (TB_ACC),
    .WE_CYC   (TB_WE),
    .TURN_CYC (TB_TURN)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .busy       (busy),
    .done       (done),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural memory: 64 words indexed by the low address bits.
  logic [DW-1:0] model_mem [64];
  logic [DW-1:0] shadow    [64];
  int            oe_low_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) model_mem[i] <= DW'(i) ^ 8'h3C;
      oe_low_cnt <= 0;
    end else begin
      if (!mem_cs_n && !mem_oe_n && mem_we_n) oe_low_cnt <= oe_low_cnt + 1;
      else oe_low_cnt <= 0;
      if (!mem_cs_n && !mem_we_n && mem_dq_oe) model_mem[mem_addr[5:0]] <= mem_dq_out;
    end
  end

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n && (oe_low_cnt >= TB_ACC - 1))
                     ? model_mem[mem_addr[5:0]] : 8'hA5;

  task automatic shadow_init();
    for (int i = 0; i < 64; i++) shadow[i] = DW'(i) ^ 8'h3C;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // Called at a negedge; returns at the negedge of the done cycle.
  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int gap);
    int i;
    int n_rd, n_wr, n_hold, n_gap, bad_addr, bad_data, bad_busy, clash;
    int exp_lat;
    logic [DW-1:0] exp_rd;
    n_rd = 0; n_wr = 0; n_hold = 0; n_gap = 0;
    bad_addr = 0; bad_data = 0; bad_busy = 0; clash = 0;
    exp_rd = shadow[a[5:0]];
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    i = 1;
    while (!done && i < 200) begin
      if (!busy) bad_busy++;
      if (!mem_cs_n && mem_addr != a) bad_addr++;
      if (!mem_cs_n && !mem_oe_n && mem_we_n) n_rd++;
      if (!mem_cs_n && !mem_we_n && mem_oe_n) begin
        n_wr++;
        if (mem_dq_out != d || !mem_dq_oe) bad_data++;
      end
      if (mem_dq_oe && mem_we_n) n_hold++;
      if (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe) n_gap++;
      if (!mem_oe_n && (!mem_we_n || mem_dq_oe)) clash++;
      @(negedge clk);
      i++;
    end
    chk(bad_busy == 0, "R9 busy during op", bad_busy, 0);
    chk(!busy, "R9 busy low with done", busy, 0);
    chk(bad_addr == 0, "R11 address held", bad_addr, 0);
    chk(clash == 0, "R10 no bus clash", clash, 0);
    if (wr) begin
      exp_lat = TB_WE + 2 + gap;
      chk(i == exp_lat, gap > 0 ? "R6 write latency after read" : "R7 write latency",
          i, exp_lat);
      chk(n_wr == TB_WE, "R4 write strobe cycles", n_wr, TB_WE);
      chk(bad_data == 0, "R4 write data on bus", bad_data, 0);
      chk(n_hold == 1, "R5 drive after we rise", n_hold, 1);
      chk(n_gap == gap, "R6 turnaround gap", n_gap, gap);
      shadow[a[5:0]] = d;
    end else begin
      exp_lat = TB_ACC + 1;
      chk(i == exp_lat, "R3 read latency", i, exp_lat);
      chk(n_rd == TB_ACC, "R2 read strobe cycles", n_rd, TB_ACC);
      chk(rsp_rdata == exp_rd, "R3 read data", rsp_rdata, exp_rd);
    end
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 idle strobes at done",
        {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    bit prev_rd;
    int extra_done;
    int cs_act;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    shadow_init();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !busy && !done,
        "R1 reset outputs", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, busy, done}, 6'b111000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table
    prev_rd = 1'b0;
    for (int v = 0; v < NVEC; v++) begin
      do_op(VECS[v].wr, VECS[v].addr, VECS[v].data,
            (VECS[v].wr && prev_rd) ? TB_TURN - 1 : 0);
      prev_rd = !VECS[v].wr;
    end

    // R7: write after an idle stretch skips the turnaround
    repeat (TB_TURN + 1) @(negedge clk);
    do_op(1'b1, 15'h0C22, 8'hC3, 0);
    // R12: read data held through the write and idle cycles
    repeat (3) @(negedge clk);
    chk(rsp_rdata == 8'h96, "R12 read data held", rsp_rdata, 8'h96);

    // R8: request while busy is ignored
    req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h0107; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0108; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_addr == 15'h0107, "R8 address untouched", mem_addr, 15'h0107);
    while (!done) @(negedge clk);
    chk(rsp_rdata == shadow[7], "R8 original read completes", rsp_rdata, shadow[7]);
    @(negedge clk);
    chk(!done, "R3 done lasts one cycle", done, 0);
    extra_done = 0; cs_act = 0;
    for (int k = 0; k < 10; k++) begin
      if (done) extra_done++;
      if (!mem_cs_n) cs_act++;
      @(negedge clk);
    end
    chk(extra_done == 0, "R8 no extra done", extra_done, 0);
    chk(cs_act == 0, "R8 no extra access", cs_act, 0);
    do_op(1'b0, 15'h0108, 8'h00, 0);
    chk(rsp_rdata == (8'h08 ^ 8'h3C), "R8 memory untouched", rsp_rdata, 8'h08 ^ 8'h3C);

    // R1: asynchronous reset in the middle of a write
    repeat (TB_TURN + 1) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0030; req_wdata = 8'h42;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_we_n, "R4 write strobe active", mem_we_n, 0);
    rst_n = 1'b0;
    #1;
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !busy && !done,
        "R1 async reset mid write", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, busy, done},
        6'b111000);
    @(negedge clk);
    rst_n = 1'b1;
    shadow_init();
    repeat (4) @(negedge clk);
    do_op(1'b0, 15'h0015, 8'h00, 0);

    summary();
    $finish;
  end

endmodule